// File: doc/BRIEF.md
# Character Parity Strip and Longitudinal Check Bridge

This block sits between a processor-side character stream and a block store. Each processor-side character is six data bits with one odd-parity bit above them. When writing, the bridge checks every incoming character and drops its parity bit. It keeps a running exclusive-OR of the six-bit data words. After the last data word it sends that longitudinal word to the store as the block's trailer.

When reading, the bridge takes six-bit words from the store and builds a fresh odd-parity bit for each one before handing it to the processor side. It folds every word into the same running exclusive-OR. The word that follows the last data word is taken as the stored trailer and compared with the running value.

A transfer begins with a one-cycle start pulse. The pulse carries the direction and the block length, counted in data characters. A parity failure raises a one-cycle error request and sets a sticky flag of its own kind. On the write side a failure ends the transfer at once, unless the continue-on-error control is held high. A done pulse marks the end of every transfer.

Top module: `blk_parity_bridge`

## Requirements
- R1: After reset, busy, wr_valid, out_valid, done, err_irq, char_err and lrc_err are all 0.
- R2: In a write transfer, an accepted character (in_valid high) whose seven bits hold an odd number of ones appears on wr_word as its low six bits, with wr_valid high, one cycle later. Bit 6 is the parity bit and is never passed on.
- R3: In a write transfer, one cycle after the word for the last of blk_len characters, wr_valid is high and wr_word carries the bitwise XOR of all data words of the block. done pulses high for one cycle in that same cycle, and busy is low.
- R4: In a read transfer, each of the first blk_len words accepted on rd_word (rd_valid high) appears one cycle later on out_char bits 5:0, with out_valid high. Bit 6 is set so that the seven bits hold an odd number of ones.
- R5: In a read transfer, the word accepted after the blk_len data words is the trailer. It produces no out_valid. One cycle later done pulses. If the XOR of all data words and the trailer is non-zero, lrc_err is set and err_irq pulses in that same cycle.
- R6: In a write transfer with ovr_en low, a character with an even number of ones is not written. One cycle later err_irq and done pulse, char_err is set, busy is low, and no trailer follows.
- R7: In a write transfer with ovr_en high, a character with an even number of ones sets char_err and pulses err_irq. Its low six bits are still written and included in the trailer, and the transfer completes normally.
- R8: char_err and lrc_err hold their value until a start pulse is accepted, which clears both.
- R9: A write with blk_len 0 writes a trailer of 0 with done one cycle after the start cycle. A read with blk_len 0 treats the first word accepted as the trailer.
- R10: A start pulse while busy is ignored, and in_valid or rd_valid while idle writes or outputs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; direction and length are sampled with it |
| dir_rd | input | 1 | 1 = read from store, 0 = write to store |
| blk_len | input | LEN_W | Number of data characters in the block |
| ovr_en | input | 1 | Continue the transfer after a character parity error |
| in_valid | input | 1 | Processor-side character present |
| in_char | input | DW+1 | Character, parity in the top bit |
| wr_valid | output | 1 | Word to store valid |
| wr_word | output | DW | Stripped data word or trailer |
| rd_valid | input | 1 | Word from store present |
| rd_word | input | DW | Data word or trailer from store |
| out_valid | output | 1 | Processor-side character out valid |
| out_char | output | DW+1 | Character with regenerated parity in the top bit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_irq | output | 1 | One-cycle error request |
| char_err | output | 1 | Sticky character-parity error |
| lrc_err | output | 1 | Sticky longitudinal error |

## Verification
The hardest state to reach is a write with a bad character while the override is held. In that state an error has been reported, yet the data word still enters the longitudinal sum, and the trailer must come out after it. The stimulus builds a three-character block with a deliberately even-weight middle character. It then checks the word, the error pulse and the trailer value cycle by cycle. A fresh start then shows the sticky flag clearing. Zero-length blocks in both directions and a start pulse landing mid-transfer cover the counter's edge conditions.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } lbp_state_e;
endpackage

// File: rtl/lbp_rst_sync.sv
module lbp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lbp_par_unit.sv
module lbp_par_unit #(
  parameter int DW = 6
) (
  input  logic [DW:0]   chk_char,
  output logic          chk_ok,
  input  logic [DW-1:0] gen_word,
  output logic [DW:0]   gen_char
);
  // odd parity: total ones across data and parity bit is odd
  assign chk_ok   = ^chk_char;
  assign gen_char = {~(^gen_word), gen_word};
endmodule

// File: rtl/lbp_lrc_acc.sv
module lbp_lrc_acc #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc_en,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] trail_word,
  output logic [DW-1:0] lrc_q,
  output logic          lrc_ok
);
  logic [DW-1:0] lrc_d;

  always_comb begin
    lrc_d = lrc_q;
    if (clr)         lrc_d = '0;
    else if (acc_en) lrc_d = lrc_q ^ din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lrc_q <= '0;
    else if (clr || acc_en)   lrc_q <= lrc_d;
  end

  assign lrc_ok = ((lrc_q ^ trail_word) == '0);
endmodule

// File: rtl/lbp_ctrl.sv
module lbp_ctrl
  import lbp_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_rd,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             ovr_en,
  input  logic             in_valid,
  input  logic             in_ok,
  input  logic             rd_valid,
  input  logic             lrc_ok,
  output logic             clr,
  output logic             acc_en,
  output logic             wr_data_en,
  output logic             wr_trail_en,
  output logic             rd_data_en,
  output logic             finish,
  output logic             char_bad,
  output logic             lrc_bad,
  output logic             busy,
  output logic             rd_mode
);
  lbp_state_e       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    clr         = 1'b0;
    acc_en      = 1'b0;
    wr_data_en  = 1'b0;
    wr_trail_en = 1'b0;
    rd_data_en  = 1'b0;
    finish      = 1'b0;
    char_bad    = 1'b0;
    lrc_bad     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          clr     = 1'b1;
          cnt_d   = blk_len;
          state_d = dir_rd ? ST_RD : ST_WR;
        end
      end
      ST_WR: begin
        if (cnt_zero) begin
          wr_trail_en = 1'b1;
          finish      = 1'b1;
          state_d     = ST_IDLE;
        end else if (in_valid) begin
          char_bad = !in_ok;
          if (in_ok || ovr_en) begin
            acc_en     = 1'b1;
            wr_data_en = 1'b1;
            cnt_d      = cnt_q - LEN_W'(1);
          end else begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_RD: begin
        if (rd_valid) begin
          if (!cnt_zero) begin
            acc_en     = 1'b1;
            rd_data_en = 1'b1;
            cnt_d      = cnt_q - LEN_W'(1);
          end else begin
            lrc_bad = !lrc_ok;
            finish  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_d != cnt_q) cnt_q <= cnt_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign rd_mode = (state_q == ST_RD);
endmodule

// File: rtl/blk_parity_bridge.sv
module blk_parity_bridge #(
  parameter int DW    = 6,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_rd,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             ovr_en,
  input  logic             in_valid,
  input  logic [DW:0]      in_char,
  output logic             wr_valid,
  output logic [DW-1:0]    wr_word,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rd_word,
  output logic             out_valid,
  output logic [DW:0]      out_char,
  output logic             busy,
  output logic             done,
  output logic             err_irq,
  output logic             char_err,
  output logic             lrc_err
);
  logic          rst_i_n;
  logic          in_ok, lrc_ok;
  logic [DW:0]   gen_char;
  logic [DW-1:0] lrc_q, acc_din;
  logic          clr, acc_en, wr_data_en, wr_trail_en, rd_data_en;
  logic          finish, char_bad, lrc_bad, rd_mode;

  logic          wr_valid_d, out_valid_d, done_d, err_irq_d;
  logic          char_err_d, lrc_err_d;
  logic [DW-1:0] wr_word_d;
  logic [DW:0]   out_char_d;

  lbp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  lbp_par_unit #(.DW(DW)) u_par (
    .chk_char(in_char), .chk_ok(in_ok),
    .gen_word(rd_word), .gen_char(gen_char)
  );

  assign acc_din = rd_mode ? rd_word : in_char[DW-1:0];

  lbp_lrc_acc #(.DW(DW)) u_lrc (
    .clk(clk), .rst_n(rst_i_n), .clr(clr), .acc_en(acc_en),
    .din(acc_din), .trail_word(rd_word), .lrc_q(lrc_q), .lrc_ok(lrc_ok)
  );

  lbp_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .start(start), .dir_rd(dir_rd),
    .blk_len(blk_len), .ovr_en(ovr_en), .in_valid(in_valid),
    .in_ok(in_ok), .rd_valid(rd_valid), .lrc_ok(lrc_ok),
    .clr(clr), .acc_en(acc_en), .wr_data_en(wr_data_en),
    .wr_trail_en(wr_trail_en), .rd_data_en(rd_data_en),
    .finish(finish), .char_bad(char_bad), .lrc_bad(lrc_bad),
    .busy(busy), .rd_mode(rd_mode)
  );

  always_comb begin
    wr_valid_d  = wr_data_en || wr_trail_en;
    wr_word_d   = wr_trail_en ? lrc_q : in_char[DW-1:0];
    out_valid_d = rd_data_en;
    out_char_d  = rd_data_en ? gen_char : out_char;
    done_d      = finish;
    err_irq_d   = char_bad || lrc_bad;
    char_err_d  = clr ? 1'b0 : (char_err || char_bad);
    lrc_err_d   = clr ? 1'b0 : (lrc_err || lrc_bad);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wr_valid  <= 1'b0;
      wr_word   <= '0;
      out_valid <= 1'b0;
      out_char  <= '0;
      done      <= 1'b0;
      err_irq   <= 1'b0;
      char_err  <= 1'b0;
      lrc_err   <= 1'b0;
    end else begin
      wr_valid  <= wr_valid_d;
      if (wr_valid_d) wr_word <= wr_word_d;
      out_valid <= out_valid_d;
      out_char  <= out_char_d;
      done      <= done_d;
      err_irq   <= err_irq_d;
      char_err  <= char_err_d;
      lrc_err   <= lrc_err_d;
    end
  end
endmodule

// File: rtl/lbp_bridge_chk.sv
module lbp_bridge_chk #(
  parameter int DW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          wr_valid,
  input logic          out_valid,
  input logic [DW:0]   out_char,
  input logic          done,
  input logic          err_irq,
  input logic          char_err,
  input logic          lrc_err
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !wr_valid); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (char_err || lrc_err)); // R6
  AST_OUT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_char) % 2 == 1)); // R4
  AST_CHAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (char_err && !(start && !busy)) |=> char_err); // R8
  AST_LRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lrc_err && !(start && !busy)) |=> lrc_err); // R8
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && out_valid)); // R2
endmodule

bind blk_parity_bridge lbp_bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .wr_valid(wr_valid), .out_valid(out_valid), .out_char(out_char),
  .done(done), .err_irq(err_irq), .char_err(char_err), .lrc_err(lrc_err)
);

// File: tb/blk_parity_bridge_bench.sv
module blk_parity_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 6;
  localparam int LEN_W = 10;
  localparam int NV = 8;
  localparam logic [DW-1:0] VEC [NV] = '{6'h00, 6'h3F, 6'h15, 6'h2A,
                                          6'h01, 6'h20, 6'h0E, 6'h33};

  logic clk = 1'b0;
  logic rst_n, start, dir_rd, ovr_en, in_valid, rd_valid;
  logic [LEN_W-1:0] blk_len;
  logic [DW:0] in_char;
  logic [DW-1:0] rd_word;
  logic wr_valid, out_valid, busy, done, err_irq, char_err, lrc_err;
  logic [DW-1:0] wr_word;
  logic [DW:0] out_char;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] exp_lrc;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_parity_bridge #(.DW(DW), .LEN_W(LEN_W)) u_blk_parity_bridge (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd),
    .blk_len(blk_len), .ovr_en(ovr_en), .in_valid(in_valid),
    .in_char(in_char), .wr_valid(wr_valid), .wr_word(wr_word),
    .rd_valid(rd_valid), .rd_word(rd_word), .out_valid(out_valid),
    .out_char(out_char), .busy(busy), .done(done), .err_irq(err_irq),
    .char_err(char_err), .lrc_err(lrc_err)
  );

  function automatic logic [DW:0] good(input logic [DW-1:0] d);
    return {~(^d), d};
  endfunction

  function automatic logic [DW:0] bad(input logic [DW-1:0] d);
    return {^d, d};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic begin_xfer(input logic rd, input int len);
    start = 1'b1; dir_rd = rd; blk_len = LEN_W'(len);
    tick();
    start = 1'b0;
  endtask

  task automatic put_char(input logic [DW:0] c);
    in_valid = 1'b1; in_char = c;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic put_word(input logic [DW-1:0] w);
    rd_valid = 1'b1; rd_word = w;
    tick();
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 0; dir_rd = 0; ovr_en = 0; in_valid = 0;
    rd_valid = 0; blk_len = '0; in_char = '0; rd_word = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1
    chk({busy, wr_valid, out_valid, done, err_irq, char_err, lrc_err} == 7'b0,
        "R1", {busy, wr_valid, out_valid, done, err_irq, char_err, lrc_err}, 0);

    // R2/R3 table walk, write
    exp_lrc = '0;
    begin_xfer(1'b0, NV);
    for (int i = 0; i < NV; i++) begin
      put_char(good(VEC[i]));
      exp_lrc ^= VEC[i];
      chk(wr_valid && wr_word == VEC[i], "R2", {wr_valid, wr_word}, {1'b1, VEC[i]});
    end
    tick();
    chk(wr_valid && wr_word == exp_lrc && done && !busy, "R3",
        {done, wr_valid, wr_word}, {2'b11, exp_lrc});
    tick();
    chk(!done && !char_err, "R3", {done, char_err}, 0);

    // R4/R5 table walk, read with correct trailer
    begin_xfer(1'b1, NV);
    for (int i = 0; i < NV; i++) begin
      put_word(VEC[i]);
      chk(out_valid && out_char == good(VEC[i]), "R4", {out_valid, out_char},
          {1'b1, good(VEC[i])});
    end
    put_word(exp_lrc);
    chk(!out_valid && done && !lrc_err && !err_irq, "R5",
        {out_valid, done, lrc_err, err_irq}, 4'b0100);

    // R5 wrong trailer
    begin_xfer(1'b1, 2);
    put_word(6'h05); put_word(6'h11);
    put_word(6'h15);
    chk(done && lrc_err && err_irq, "R5", {done, lrc_err, err_irq}, 3'b111);
    tick();
    chk(lrc_err && !err_irq, "R8", {lrc_err, err_irq}, 2'b10);

    // R8 start clears lrc_err; R6 error terminates write
    begin_xfer(1'b0, 4);
    chk(!lrc_err && !char_err, "R8", {lrc_err, char_err}, 0);
    put_char(good(6'h0C));
    put_char(bad(6'h07));
    chk(!wr_valid && err_irq && done && char_err && !busy, "R6",
        {wr_valid, err_irq, done, char_err, busy}, 5'b01110);
    put_char(good(6'h09));
    chk(!wr_valid && !done && char_err, "R6", {wr_valid, done, char_err}, 3'b001);

    // R7 override
    ovr_en = 1'b1;
    begin_xfer(1'b0, 3);
    chk(!char_err, "R8", char_err, 0);
    put_char(good(6'h12));
    put_char(bad(6'h2C));
    chk(wr_valid && wr_word == 6'h2C && err_irq && char_err && !done, "R7",
        {wr_valid, wr_word, err_irq, char_err, done}, {1'b1, 6'h2C, 3'b110});
    put_char(good(6'h03));
    tick();
    chk(wr_valid && wr_word == (6'h12 ^ 6'h2C ^ 6'h03) && done && char_err, "R7",
        {wr_valid, wr_word, done}, {1'b1, 6'h12 ^ 6'h2C ^ 6'h03, 1'b1});
    ovr_en = 1'b0;

    // R9 zero-length write and read
    begin_xfer(1'b0, 0);
    tick();
    chk(wr_valid && wr_word == 0 && done, "R9", {wr_valid, wr_word, done}, {1'b1, 6'h0, 1'b1});
    begin_xfer(1'b1, 0);
    put_word(6'h00);
    chk(done && !lrc_err && !out_valid, "R9", {done, lrc_err, out_valid}, 3'b100);

    // R10 start while busy ignored
    begin_xfer(1'b0, 2);
    start = 1'b1; dir_rd = 1'b1; blk_len = LEN_W'(5);
    put_char(good(6'h21));
    start = 1'b0;
    chk(wr_valid && wr_word == 6'h21 && busy, "R10", {wr_valid, wr_word, busy}, {1'b1, 6'h21, 1'b1});
    put_char(good(6'h30));
    tick();
    chk(wr_valid && wr_word == (6'h21 ^ 6'h30) && done, "R10",
        {wr_valid, wr_word, done}, {1'b1, 6'h11, 1'b1});

    // R10 idle inputs ignored
    in_valid = 1'b1; in_char = good(6'h2F); rd_valid = 1'b1; rd_word = 6'h2F;
    tick(); tick();
    chk(!wr_valid && !out_valid && !busy && !done, "R10",
        {wr_valid, out_valid, busy, done}, 0);
    in_valid = 1'b0; rd_valid = 1'b0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule